// File: doc/BRIEF.md
# Two-Lane Interleaved Multiplier

This unit multiplies two unsigned 16-bit operands and can take a new pair on every clock, even though each multiply is given two full clock periods to settle. It holds two copies of the multiplier. A single select flop flips on every edge and sends the samples to the two copies in turn: even-numbered samples go to one lane and odd-numbered samples to the other. Each lane keeps its operands for two cycles. A select-driven multiplexer then loads the finished lane's result into one output register.

Seen from its ports, the unit acts like one pipelined multiplier with a fixed depth of three cycles. Results come out in the same order as their operands went in. A valid flag travels alongside each sample, and operands are sampled every cycle whether or not the flag is set. The lane that a sample lands in therefore depends only on how many cycles have passed since reset, never on gaps in the valid stream.

Top module: `imul2_top`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, out_valid is 0, out_prod is 0 and the lane select is 0, meaning the even lane captures first.
- R2: Once three clocks have passed since reset was released, out_prod in every cycle equals the unsigned 32-bit product of the in_a and in_b that were presented three cycles earlier.
- R3: out_valid is 1 in a cycle exactly when in_valid was 1 three cycles earlier, with that earlier cycle falling after the last reset clock. In every other cycle it is 0.
- R4: A valid pair may arrive on every cycle back to back. Every one of them yields a product, in input order, with no sample lost or repeated.
- R5: The lane select inverts on every clock outside reset, whatever in_valid is doing. Gapped valid patterns therefore give the same results as continuous ones.
- R6: Each lane's operand register changes only on the edges where the select names that lane, so it holds a captured pair for two consecutive cycles.
- R7: The full-scale operands 0xFFFF by 0xFFFF give 0xFFFE0001, and a zero in either operand gives 0, including when such pairs arrive back to back.
- R8: A reset asserted in the middle of a stream discards every sample still in flight. No out_valid appears until three cycles after the first valid sample that follows the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the operand pair of this cycle as a real sample |
| in_a | input | 16 | First unsigned operand |
| in_b | input | 16 | Second unsigned operand |
| out_valid | output | 1 | Marks out_prod as the product of a real sample |
| out_prod | output | 32 | Registered unsigned product |

## Verification
The bench targets lane alternation. It streams full-scale and zero operands back to back, so that a multiplexer sampling the wrong lane, or a lane register capturing on the wrong phase, would emit the neighbouring sample's product or a repeated one. It thins the valid flag to every second and every third cycle. A select that paused on idle cycles would then swap lanes, and the products would arrive misaligned. A reset dropped into a busy stream checks that no stale result or stray valid leaks out afterwards, and the latency of every product is checked against its exact due cycle, which catches an off-by-one valid shift.

// File: rtl/imul2_pkg.sv
package imul2_pkg;

    localparam int unsigned DEF_A_W   = 16;
    localparam int unsigned DEF_B_W   = 16;
    localparam int unsigned NUM_LANES = 2;
    // cycles from operand presentation to registered product
    localparam int unsigned PIPE_LAT  = 3;
    // valid stages held in the steering block; the last stage lives in the output register
    localparam int unsigned VLD_STAGES = PIPE_LAT - 1;

    typedef enum logic {
        LANE_EVEN = 1'b0,
        LANE_ODD  = 1'b1
    } lane_e;

endpackage

// File: rtl/imul2_steer.sv
module imul2_steer
    import imul2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output lane_e sel,
    output logic  vld_tail
);

    logic [VLD_STAGES-1:0] vld_sr;

    // the select free-runs; idle cycles still advance it
    always_ff @(posedge clk) begin
        if (rst) begin
            sel    <= LANE_EVEN;
            vld_sr <= '0;
        end else begin
            sel    <= (sel == LANE_EVEN) ? LANE_ODD : LANE_EVEN;
            vld_sr <= {vld_sr[VLD_STAGES-2:0], in_valid};
        end
    end

    assign vld_tail = vld_sr[VLD_STAGES-1];

endmodule

// File: rtl/imul2_lane.sv
module imul2_lane
    import imul2_pkg::*;
#(
    parameter int unsigned A_W     = DEF_A_W,
    parameter int unsigned B_W     = DEF_B_W,
    parameter int unsigned LANE_ID = 0,
    localparam int unsigned P_W    = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst,
    input  lane_e          sel,
    input  logic [A_W-1:0] in_a,
    input  logic [B_W-1:0] in_b,
    output logic [A_W-1:0] op_a,
    output logic [B_W-1:0] op_b,
    output logic [P_W-1:0] prod
);

    logic cap_en;
    assign cap_en = (sel == lane_e'(LANE_ID[0]));

    always_ff @(posedge clk) begin
        if (rst) begin
            op_a <= '0;
            op_b <= '0;
        end else if (cap_en) begin
            op_a <= in_a;
            op_b <= in_b;
        end
    end

    // two-cycle path: operands are held for two clocks before the product is taken
    always_comb begin
        prod = P_W'(op_a) * P_W'(op_b);
    end

endmodule

// File: rtl/imul2_merge.sv
module imul2_merge
    import imul2_pkg::*;
#(
    parameter int unsigned P_W = DEF_A_W + DEF_B_W
) (
    input  logic           clk,
    input  logic           rst,
    input  lane_e          sel,
    input  logic [P_W-1:0] lane_prod [NUM_LANES],
    input  logic           vld_tail,
    output logic [P_W-1:0] out_prod,
    output logic           out_valid
);

    // sel has flipped twice since the chosen lane captured, so it names that lane again
    always_ff @(posedge clk) begin
        if (rst) begin
            out_prod  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_prod  <= lane_prod[int'(sel)];
            out_valid <= vld_tail;
        end
    end

endmodule

// File: rtl/imul2_top.sv
module imul2_top
    import imul2_pkg::*;
#(
    parameter int unsigned A_W  = DEF_A_W,
    parameter int unsigned B_W  = DEF_B_W,
    localparam int unsigned P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [A_W-1:0] in_a,
    input  logic [B_W-1:0] in_b,
    output logic           out_valid,
    output logic [P_W-1:0] out_prod
);

    lane_e          sel;
    logic           vld_tail;
    logic [A_W-1:0] lane_a    [NUM_LANES];
    logic [B_W-1:0] lane_b    [NUM_LANES];
    logic [P_W-1:0] lane_prod [NUM_LANES];

    imul2_steer u_steer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .sel      (sel),
        .vld_tail (vld_tail)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        imul2_lane #(
            .A_W     (A_W),
            .B_W     (B_W),
            .LANE_ID (g)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .sel  (sel),
            .in_a (in_a),
            .in_b (in_b),
            .op_a (lane_a[g]),
            .op_b (lane_b[g]),
            .prod (lane_prod[g])
        );
    end

    imul2_merge #(
        .P_W (P_W)
    ) u_merge (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .lane_prod (lane_prod),
        .vld_tail  (vld_tail),
        .out_prod  (out_prod),
        .out_valid (out_valid)
    );

endmodule

// File: rtl/imul2_chk.sv
module imul2_chk #(
    parameter int unsigned A_W  = 16,
    parameter int unsigned B_W  = 16,
    localparam int unsigned P_W = A_W + B_W
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [A_W-1:0] in_a,
    input logic [B_W-1:0] in_b,
    input logic           out_valid,
    input logic [P_W-1:0] out_prod,
    input logic           sel,
    input logic [A_W-1:0] lane0_a,
    input logic [B_W-1:0] lane0_b,
    input logic [A_W-1:0] lane1_a,
    input logic [B_W-1:0] lane1_b
);

    // clocks since reset release, saturating at the pipeline depth
    logic [1:0] settle;
    always_ff @(posedge clk) begin
        if (rst)                settle <= 2'd0;
        else if (settle != 2'd3) settle <= settle + 2'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (sel == 1'b0) && !out_valid && (out_prod == '0));

    assert_product_R2: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd3) |-> out_prod == (P_W'($past(in_a, 3)) * P_W'($past(in_b, 3))));

    assert_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd3) |-> out_valid == $past(in_valid, 3));

    assert_no_early_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (settle != 2'd3) |-> !out_valid);

    assert_select_toggles_R5: assert property (@(posedge clk) disable iff (rst)
        (settle >= 2'd2) |-> sel != $past(sel));

    assert_even_lane_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (settle >= 2'd2) && $past(sel) |-> $stable(lane0_a) && $stable(lane0_b));

    assert_odd_lane_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (settle >= 2'd2) && !$past(sel) |-> $stable(lane1_a) && $stable(lane1_b));

endmodule

bind imul2_top imul2_chk #(
    .A_W (A_W),
    .B_W (B_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod),
    .sel       (sel),
    .lane0_a   (lane_a[0]),
    .lane0_b   (lane_b[0]),
    .lane1_a   (lane_a[1]),
    .lane1_b   (lane_b[1])
);

// File: tb/imul2_top_tb.sv
module imul2_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int A_W = 16;
    localparam int B_W = 16;
    localparam int P_W = A_W + B_W;

    typedef struct {
        longint     due;
        bit         vld;
        logic [P_W-1:0] prod;
        string      req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [A_W-1:0] in_a = '0;
    logic [B_W-1:0] in_b = '0;
    logic           out_valid;
    logic [P_W-1:0] out_prod;

    exp_t   sb_q[$];
    longint pcount = 0;
    int     n_checks = 0;
    int     n_fails = 0;
    bit     mon_on = 1'b0;
    bit     done = 1'b0;

    imul2_top #(.A_W(A_W), .B_W(B_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) pcount <= pcount + 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h at cycle %0d", req, what, act, exp, pcount);
        end
    endtask

    // driver: one operand pair per cycle, expected result queued with its due cycle
    task automatic drive(logic [A_W-1:0] a, logic [B_W-1:0] b, bit v, string req);
        exp_t e;
        @(negedge clk);
        #1;
        in_a = a;
        in_b = b;
        in_valid = v;
        e.due  = pcount + 3;
        e.vld  = v;
        e.prod = P_W'(a) * P_W'(b);
        e.req  = req;
        sb_q.push_back(e);
    endtask

    task automatic do_reset(int cycles);
        @(negedge clk);
        #1;
        rst = 1'b1;
        in_valid = 1'b0;
        sb_q.delete();
        @(negedge clk);
        // R1: reset state visible at the ports
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        check(out_prod == '0, "R1", "out_prod in reset", longint'(out_prod), 0);
        repeat (cycles) @(negedge clk);
        #1;
        rst = 1'b0;
    endtask

    // monitor: pops due entries, otherwise demands a quiet out_valid
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && !rst) begin
                if (sb_q.size() > 0 && sb_q[0].due == pcount) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(out_valid == e.vld, "R3", "out_valid", longint'(out_valid), longint'(e.vld));
                    check(out_prod == e.prod, e.req, "out_prod", longint'(out_prod), longint'(e.prod));
                end else begin
                    check(out_valid == 1'b0, "R8", "stray out_valid", longint'(out_valid), 0);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [A_W-1:0] ra;
        logic [B_W-1:0] rb;
        repeat (3) @(negedge clk);
        mon_on = 1'b1;
        do_reset(2);

        // R7: full-scale and zero operands back to back
        for (int i = 0; i < 8; i++) drive(16'hFFFF, 16'hFFFF, 1'b1, "R7");
        for (int i = 0; i < 4; i++) drive(16'h0000, 16'hFFFF, 1'b1, "R7");
        for (int i = 0; i < 4; i++) begin
            drive(16'hFFFF, 16'hFFFF, 1'b1, "R7");
            drive(16'hFFFF, 16'h0000, 1'b1, "R7");
        end

        // R4: continuous distinct stream, order preserved
        for (int i = 1; i <= 40; i++) drive(A_W'(i * 977), B_W'(i * 31 + 5), 1'b1, "R4");

        // R5: valid on every second cycle, then every third
        for (int i = 0; i < 20; i++) drive(A_W'(i * 4099 + 3), B_W'(i * 257 + 1), (i % 2) == 0, "R5");
        for (int i = 0; i < 21; i++) drive(A_W'(i * 211 + 7), B_W'(65535 - i * 13), (i % 3) == 0, "R5");

        // R2: pseudo-random operands and valid, data checked every cycle
        for (int i = 0; i < 200; i++) begin
            ra = A_W'($urandom);
            rb = B_W'($urandom);
            drive(ra, rb, ($urandom % 4) != 0, "R2");
        end

        // R8: reset in the middle of a busy stream
        for (int i = 0; i < 5; i++) drive(A_W'(1000 + i), B_W'(2000 + i), 1'b1, "R8");
        do_reset(1);
        for (int i = 0; i < 3; i++) drive(A_W'(0), B_W'(0), 1'b0, "R8");
        for (int i = 0; i < 10; i++) drive(A_W'(300 + i), B_W'(i + 9), 1'b1, "R8");

        // R6: a lane hold fault would corrupt alternating distinct pairs
        for (int i = 0; i < 16; i++) drive(A_W'(i[0] ? 16'hAAAA : 16'h5555), B_W'(i + 1), 1'b1, "R6");

        // drain
        for (int i = 0; i < 6; i++) drive('0, '0, 1'b0, "R3");
        repeat (4) @(negedge clk);
        check(sb_q.size() <= 3, "R4", "scoreboard residue", longint'(sb_q.size()), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule